// File: doc/BRIEF.md
# Inter-Core Interrupt Hub

This block lets any of `N_CORES` processors raise an interrupt on a peer, and lets the receiving processor find out which peers raised it and dismiss each one. Every core has its own command port, made of a valid strobe, a command code and a parameter byte, and its own 32-bit result register. Each core also has one interrupt line that the hub drives.

For every receiving core, the hub keeps one pending bit for each possible sender. If several peers raise the same receiver before it responds, the requests merge onto one asserted line. The receiver then sees a mask with several bits set and clears them one at a time. Software can also ask whether a target already has something pending before it raises that target. This lets redundant requests be skipped.

Commands from all cores in a cycle are applied together at the next clock edge. Queries return the state as it stood before that edge.

Top module: `xcore_irq_hub`

## Requirements
- R1: While reset is applied and after it is released, every pending bit is clear, every `irq_out` line is low and every readback register reads 0.
- R2: Command code 0x0 (raise), issued by core s with parameter t, sets sender bit s in core t's pending vector. `irq_out[t]` is high from the clock edge that accepts the command.
- R3: A raise whose target equals the issuing core, or whose target is `N_CORES` or more, changes no pending bit.
- R4: Command code 0x2 (peek), with parameter t less than `N_CORES`, loads the caller's readback with 1 if core t had any pending bit before that edge, and with 0 otherwise.
- R5: Command code 0x3 (who) loads the caller's readback with the caller's own pending vector as it stood before that edge. Bit s stands for sender s, so the values are 1, 2, 4 and 8 for cores 0 to 3, and the upper bits are zero.
- R6: Raises from several senders to one target in the same cycle or in different cycles merge. The target has one asserted line and sees one bit set per sender.
- R7: Command code 0x1 (ack) with parameter c clears only sender bit c of the caller's own vector. `irq_out` falls once no bit of that vector remains set.
- R8: When a raise and an ack hit the same pending bit in the same cycle, the bit ends up set.
- R9: Raise, ack and the unused codes 0x4 to 0xF leave the caller's readback unchanged. Codes 0x4 to 0xF also change no pending bit.
- R10: A command presented with `cmd_valid` low has no effect on any pending bit or readback register.
- R11: An ack with a parameter of `N_CORES` or more changes nothing, and a peek with such a parameter returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | N_CORES | Per-core command strobe |
| cmd_code | input | 4*N_CORES | Per-core command code, core c in bits [4c+3:4c] |
| cmd_param | input | 8*N_CORES | Per-core parameter, core c in bits [8c+7:8c] |
| readback | output | 32*N_CORES | Per-core result register, core c in bits [32c+31:32c] |
| irq_out | output | N_CORES | Per-core interrupt line, high while its pending vector is nonzero |

## Verification
The bench aims at raises from several senders that land on one target in the same cycle. A design that kept only one flag per receiver would report a single sender there, and the who mask would come back wrong. It also pairs a raise with an ack on the same bit in one cycle, where a clear-wins design would lose the interrupt. It issues self-raises and out-of-range targets, which a design missing the range and self checks would turn into spurious lines or aliased bits. Finally, it queries a target in the same cycle as that target's state changes, to catch a readback that reports post-update state.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    XC_RAISE = 4'h0,
    XC_ACK   = 4'h1,
    XC_PEEK  = 4'h2,
    XC_WHO   = 4'h3
  } xcmd_e;
endpackage

// File: rtl/xirq_cmd_decode.sv
module xirq_cmd_decode
  import xirq_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int SELF    = 0,
  parameter int PARAM_W = 8,
  parameter int IDX_W   = 2
) (
  input  logic                 valid,
  input  logic [CODE_W-1:0]    code,
  input  logic [PARAM_W-1:0]   param,
  output logic [N_CORES-1:0]   raise_vec,
  output logic [N_CORES-1:0]   ack_vec,
  output logic                 peek_en,
  output logic                 peek_ok,
  output logic [IDX_W-1:0]     peek_idx,
  output logic                 who_en
);
  localparam logic [PARAM_W-1:0] LIMIT  = PARAM_W'(N_CORES);
  localparam logic [PARAM_W-1:0] SELF_P = PARAM_W'(SELF);

  logic in_range;
  assign in_range = (param < LIMIT);
  assign peek_idx = param[IDX_W-1:0];

  always_comb begin
    raise_vec = '0;
    ack_vec   = '0;
    peek_en   = 1'b0;
    peek_ok   = 1'b0;
    who_en    = 1'b0;
    if (valid) begin
      case (code)
        XC_RAISE: if (in_range && param != SELF_P) raise_vec[param[IDX_W-1:0]] = 1'b1;
        XC_ACK:   if (in_range) ack_vec[param[IDX_W-1:0]] = 1'b1;
        XC_PEEK:  begin
          peek_en = 1'b1;
          peek_ok = in_range;
        end
        XC_WHO:   who_en = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/xirq_pend_bank.sv
module xirq_pend_bank #(
  parameter int N_CORES = 4,
  localparam int BITS   = N_CORES * N_CORES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set_flat,
  input  logic [BITS-1:0] clr_flat,
  output logic [BITS-1:0] pend_flat
);
  // Bit t*N_CORES+s: sender s has an interrupt pending at target t.
  logic [BITS-1:0] pend_nxt;
  logic [BITS-1:0] pend_en;

  always_comb begin
    pend_en  = set_flat | clr_flat;
    pend_nxt = set_flat | (pend_flat & ~clr_flat);
  end

  genvar k;
  generate
    for (k = 0; k < BITS; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_flat[k] <= 1'b0;
        else if (pend_en[k]) pend_flat[k] <= pend_nxt[k];
      end

      a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_flat[k] |=> pend_flat[k]);
      a_r7_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flat[k] && !set_flat[k]) |=> !pend_flat[k]);
      a_r10_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flat[k] && !clr_flat[k]) |=> $stable(pend_flat[k]));
    end
  endgenerate
endmodule

// File: rtl/xirq_readback.sv
module xirq_readback #(
  parameter int N_CORES = 4,
  parameter int RB_W    = 32,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               peek_en,
  input  logic               peek_ok,
  input  logic [IDX_W-1:0]   peek_idx,
  input  logic               who_en,
  input  logic [N_CORES-1:0] own_vec,
  input  logic [N_CORES-1:0] any_pend,
  output logic [RB_W-1:0]    rb
);
  logic [RB_W-1:0] rb_nxt;
  logic            rb_en;

  always_comb begin
    rb_en  = peek_en | who_en;
    rb_nxt = '0;
    if (who_en)                  rb_nxt[N_CORES-1:0] = own_vec;
    else if (peek_en && peek_ok) rb_nxt[0] = any_pend[peek_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rb <= '0;
    else if (rb_en) rb <= rb_nxt;
  end

  a_r11_bad_peek_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_en && !peek_ok) |=> (rb == '0));
endmodule

// File: rtl/xcore_irq_hub.sv
module xcore_irq_hub
  import xirq_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int PARAM_W = 8,
  parameter int RB_W    = 32,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int BITS   = N_CORES * N_CORES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES-1:0]        cmd_valid,
  input  logic [N_CORES*CODE_W-1:0] cmd_code,
  input  logic [N_CORES*PARAM_W-1:0] cmd_param,
  output logic [N_CORES*RB_W-1:0]   readback,
  output logic [N_CORES-1:0]        irq_out
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [N_CORES-1:0] raise_vec [N_CORES];
  logic [N_CORES-1:0] ack_vec   [N_CORES];
  logic [N_CORES-1:0] peek_en, peek_ok, who_en, any_pend;
  logic [IDX_W-1:0]   peek_idx  [N_CORES];
  logic [BITS-1:0]    set_flat, clr_flat, pend_flat;

  genvar c, s;
  generate
    for (c = 0; c < N_CORES; c++) begin : g_core
      xirq_cmd_decode #(
        .N_CORES(N_CORES), .SELF(c), .PARAM_W(PARAM_W), .IDX_W(IDX_W)
      ) u_dec (
        .valid    (cmd_valid[c]),
        .code     (cmd_code[c*CODE_W +: CODE_W]),
        .param    (cmd_param[c*PARAM_W +: PARAM_W]),
        .raise_vec(raise_vec[c]),
        .ack_vec  (ack_vec[c]),
        .peek_en  (peek_en[c]),
        .peek_ok  (peek_ok[c]),
        .peek_idx (peek_idx[c]),
        .who_en   (who_en[c])
      );

      // Row c of the bank is target c; column s is sender s.
      for (s = 0; s < N_CORES; s++) begin : g_cross
        assign set_flat[c*N_CORES + s] = raise_vec[s][c];
        assign clr_flat[c*N_CORES + s] = ack_vec[c][s];
      end

      assign any_pend[c] = |pend_flat[c*N_CORES +: N_CORES];
      assign irq_out[c]  = any_pend[c];

      xirq_readback #(
        .N_CORES(N_CORES), .RB_W(RB_W), .IDX_W(IDX_W)
      ) u_rb (
        .clk     (clk),
        .rst_n   (rst_q),
        .peek_en (peek_en[c]),
        .peek_ok (peek_ok[c]),
        .peek_idx(peek_idx[c]),
        .who_en  (who_en[c]),
        .own_vec (pend_flat[c*N_CORES +: N_CORES]),
        .any_pend(any_pend),
        .rb      (readback[c*RB_W +: RB_W])
      );

      a_r3_no_self_bit: assert property (@(posedge clk) disable iff (!rst_q)
        !pend_flat[c*N_CORES + c]);
      a_r9_rb_quiet: assert property (@(posedge clk) disable iff (!rst_q)
        !(cmd_valid[c] && (cmd_code[c*CODE_W +: CODE_W] == XC_PEEK ||
                           cmd_code[c*CODE_W +: CODE_W] == XC_WHO))
        |=> $stable(readback[c*RB_W +: RB_W]));
    end
  endgenerate

  xirq_pend_bank #(.N_CORES(N_CORES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_q),
    .set_flat (set_flat),
    .clr_flat (clr_flat),
    .pend_flat(pend_flat)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_q |=> (irq_out == '0));
endmodule

// File: tb/xcore_irq_hub_tb.sv
module xcore_irq_hub_tb;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]   cmd_valid = '0;
  logic [N*4-1:0] cmd_code  = '0;
  logic [N*8-1:0] cmd_param = '0;
  logic [N*32-1:0] readback;
  logic [N-1:0]   irq_out;

  always #2 clk = ~clk;

  xcore_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .readback(readback), .irq_out(irq_out)
  );

  int vectors = 0, errors = 0;
  int m_pend [N][N];
  int m_rb   [N];
  int s_v [N], s_c [N], s_p [N];
  string prev_tag = "R1";
  int cycles = 0;
  bit done = 0;

  task automatic compare();
    for (int t = 0; t < N; t++) begin
      int exp_irq = 0;
      for (int s = 0; s < N; s++) if (m_pend[t][s] != 0) exp_irq = 1;
      vectors++;
      if (int'(irq_out[t]) != exp_irq) begin
        errors++;
        $display("FAIL %s irq_out[%0d] actual=%0d expected=%0d", prev_tag, t, irq_out[t], exp_irq);
      end
      vectors++;
      if (readback[t*32 +: 32] != 32'(m_rb[t])) begin
        errors++;
        $display("FAIL %s readback[%0d] actual=%0h expected=%0h", prev_tag, t,
                 readback[t*32 +: 32], m_rb[t]);
      end
    end
  endtask

  task automatic model_step();
    int set [N][N];
    int clr [N][N];
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) begin set[a][b] = 0; clr[a][b] = 0; end
    for (int s = 0; s < N; s++) begin
      if (s_v[s] != 0) begin
        case (s_c[s])
          0: if (s_p[s] < N && s_p[s] != s) set[s_p[s]][s] = 1;
          1: if (s_p[s] < N) clr[s][s_p[s]] = 1;
          2: begin
            int any = 0;
            if (s_p[s] < N) for (int b = 0; b < N; b++) if (m_pend[s_p[s]][b] != 0) any = 1;
            m_rb[s] = any;
          end
          3: begin
            int vec = 0;
            for (int b = 0; b < N; b++) if (m_pend[s][b] != 0) vec += (1 << b);
            m_rb[s] = vec;
          end
          default: ;
        endcase
      end
    end
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++)
      m_pend[a][b] = (set[a][b] != 0 || (m_pend[a][b] != 0 && clr[a][b] == 0)) ? 1 : 0;
  endtask

  // Check outputs for the previous step, then drive s_* and advance the model.
  task automatic step(string tag);
    @(negedge clk);
    compare();
    for (int c = 0; c < N; c++) begin
      cmd_valid[c]        = s_v[c][0];
      cmd_code[c*4 +: 4]  = 4'(s_c[c]);
      cmd_param[c*8 +: 8] = 8'(s_p[c]);
    end
    model_step();
    prev_tag = tag;
    for (int c = 0; c < N; c++) begin s_v[c] = 0; s_c[c] = 0; s_p[c] = 0; end
  endtask

  task automatic cmd(int core, int code, int param);
    s_v[core] = 1; s_c[core] = code; s_p[core] = param;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < N; a++) begin
      m_rb[a] = 0; s_v[a] = 0; s_c[a] = 0; s_p[a] = 0;
      for (int b = 0; b < N; b++) m_pend[a][b] = 0;
    end
    repeat (3) @(negedge clk);
    compare();                              // R1 during reset
    rst_n = 1'b1;
    repeat (3) step("R1");                  // R1 after release, sync settles
    cmd(1, 0, 0);               step("R2"); // raise core0 from core1
    cmd(0, 0, 0); cmd(3, 0, 7); step("R3"); // self and out-of-range raise
    cmd(2, 0, 0); cmd(3, 0, 0); step("R6"); // coalesce two more senders
    cmd(0, 3, 0); cmd(1, 2, 0); step("R5"); // who (expect 0xE); peek target 0
    cmd(1, 2, 1); cmd(2, 2, 9); step("R4"); // peek idle target; R11 bad peek
    cmd(0, 1, 2); cmd(1, 1, 9); step("R7"); // ack bit 2; R11 bad ack
    cmd(0, 3, 0);               step("R7");
    cmd(0, 1, 1); cmd(1, 0, 0); step("R8"); // set wins over clear
    cmd(0, 3, 0);               step("R8");
    cmd(0, 5, 2); cmd(1, 15, 0);step("R9"); // unused codes
    s_c[2] = 0; s_p[2] = 0;     step("R10");// valid low with raise code
    cmd(0, 1, 1);               step("R7");
    cmd(0, 1, 3);               step("R7"); // last bit: line falls
    cmd(0, 3, 0); cmd(3, 2, 0); step("R5");
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < N; c++) begin
        s_v[c] = ($urandom_range(0, 3) != 0) ? 1 : 0;
        s_c[c] = ($urandom_range(0, 9) == 0) ? $urandom_range(4, 15) : $urandom_range(0, 3);
        s_p[c] = ($urandom_range(0, 7) == 0) ? $urandom_range(4, 255) : $urandom_range(0, 3);
      end
      step("R6");
    end
    step("R6");
    step("R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule